// File: doc/BRIEF.md
# Credit-Based Egress Priority Shaper

This block picks, at every packet boundary, which of the four priority queues of one switch egress port sends next. Queue 3 has the highest priority and queue 0 the lowest. Each queue reports whether it holds a packet and how many bytes its head packet has. A shaping mask and a 7-bit bandwidth percentage for each queue set the policy. A shaped queue earns credit while it waits and spends credit while it transmits, in the manner of an 802.1Qav credit-based shaper. It may start a packet only while its credit is not negative. Queues that are not shaped are served by plain strict priority from whatever bandwidth is left.

Shaping can apply only to a run of queues that starts at queue 3: queue 3 alone, queues 3 and 2, or queues 3, 2 and 1. A mask bit is honoured only when every bit above it is also set. The packet store and the MAC sit outside the block. The block returns a one-cycle grant pulse with the queue index, and a busy flag that stays high for one cycle per byte of the granted packet.

Top module: `egress_cbs_sel`

## Requirements
- R1: While reset is high and on the first cycle after it, `grant` and `busy` are low and `grant_q` is 0. Every credit starts at zero.
- R2: If no queue is shaped, the valid queue with the highest index is granted. No grant is issued when no queue is eligible.
- R3: Bit i of `shape_en` takes effect only when all bits of `shape_en` above i are set. Otherwise queue i is handled as a strict-priority queue and its credit is held at zero.
- R4: A shaped queue that is valid and has a credit of zero or more is granted ahead of every strict-priority queue. Among such shaped queues, the highest index wins.
- R5: For each clock in which a shaped queue is valid and not transmitting, its credit rises by its idle slope. The idle slope is floor(pct*256/100) in units of 1/256 byte.
- R6: For each byte cycle in which a shaped queue transmits, its credit changes by (idle slope - 256), because the port sends one byte per clock.
- R7: A shaped queue with negative credit is not granted. Lower queues, strict ones included, are served in its place.
- R8: When a shaped queue is empty, a positive credit is cleared to zero. A negative credit rises by the idle slope each clock but never goes above zero.
- R9: `grant` is a one-cycle pulse on the clock after the selection. `busy` then stays high for exactly the head length in cycles, and a length of 0 counts as 1. No new grant is issued while `busy` is high, and at least one idle cycle separates two packets.
- R10: `grant_q` does not change while `busy` is high, and a packet is never cut short by a higher queue becoming valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shape_en | input | NUM_Q | Shaping request, one bit per queue |
| pct | input | NUM_Q*PCT_W | Bandwidth percentage per queue, queue i at bits [i*PCT_W +: PCT_W] |
| q_valid | input | NUM_Q | Queue holds at least one packet |
| q_len | input | NUM_Q*LEN_W | Head packet length in bytes, queue i at bits [i*LEN_W +: LEN_W] |
| grant | output | 1 | One-cycle pulse when a packet starts |
| grant_q | output | QI_W | Index of the granted queue |
| busy | output | 1 | High during every byte cycle of the current packet |

## Verification
The hardest states to reach from the ports are the credit values themselves, because they are never visible. They can only be inferred from the order of grants. The bench therefore holds a shaped queue at 25 % against a strict queue that is always busy. It then compares long grant sequences with hand-computed credit trajectories. These sequences include one started right after a large positive credit was wiped while the queue was empty, and one started after a negative credit had to recover toward zero.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int CBS_FRAC_W = 8;
  typedef enum logic {PK_IDLE = 1'b0, PK_SEND = 1'b1} pk_state_e;
endpackage

// File: rtl/cbs_credit.sv
module cbs_credit #(
  parameter int PCT_W  = 7,
  parameter int FRAC_W = 8,
  parameter int CRED_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shaped,
  input  logic [PCT_W-1:0]         pct,
  input  logic                     waiting,
  input  logic                     sending,
  output logic signed [CRED_W-1:0] credit
);
  localparam int SW = PCT_W + FRAC_W;
  localparam logic signed [CRED_W:0] RATE_S = (CRED_W+1)'(1) << FRAC_W;
  localparam logic signed [CRED_W:0] CMAX = {2'b00, {(CRED_W-1){1'b1}}};
  localparam logic signed [CRED_W:0] CMIN = {2'b11, {(CRED_W-1){1'b0}}};

  logic [SW-1:0]            idle_u;
  logic signed [CRED_W:0]   idle_s, cur_x, sum, sat, nxt;

  assign idle_u = {pct, {FRAC_W{1'b0}}} / SW'(100);
  assign idle_s = signed'({{(CRED_W+1-SW){1'b0}}, idle_u});
  assign cur_x  = {credit[CRED_W-1], credit};

  always_comb begin
    if (sending) sum = cur_x + idle_s - RATE_S;
    else         sum = cur_x + idle_s;
    if (sum > CMAX)      sat = CMAX;
    else if (sum < CMIN) sat = CMIN;
    else                 sat = sum;
  end

  always_comb begin
    if (!shaped)                    nxt = '0;
    else if (sending || waiting)    nxt = sat;
    else if (cur_x > 0)             nxt = '0;
    else if (sat > 0)               nxt = '0;
    else                            nxt = sat;
  end

  always_ff @(posedge clk) begin
    if (rst) credit <= '0;
    else     credit <= nxt[CRED_W-1:0];
  end
endmodule

// File: rtl/cbs_pick.sv
module cbs_pick #(
  parameter int NUM_Q = 4,
  parameter int QI_W  = 2
) (
  input  logic [NUM_Q-1:0] elig_shaped,
  input  logic [NUM_Q-1:0] elig_strict,
  output logic             pick_vld,
  output logic [QI_W-1:0]  pick_idx
);
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (elig_strict[i]) begin
        pick_vld = 1'b1;
        pick_idx = QI_W'(i);
      end
    end
    for (int i = 0; i < NUM_Q; i++) begin
      if (elig_shaped[i]) begin
        pick_vld = 1'b1;
        pick_idx = QI_W'(i);
      end
    end
  end
endmodule

// File: rtl/cbs_pkt_timer.sv
module cbs_pkt_timer #(
  parameter int LEN_W = 12,
  parameter int QI_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pick_vld,
  input  logic [QI_W-1:0]  pick_idx,
  input  logic [LEN_W-1:0] pick_len,
  output logic             grant,
  output logic [QI_W-1:0]  grant_q,
  output logic             busy
);
  import cbs_pkg::*;
  pk_state_e        st;
  logic [LEN_W-1:0] left;

  assign busy = (st == PK_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PK_IDLE;
      left    <= '0;
      grant   <= 1'b0;
      grant_q <= '0;
    end else begin
      grant <= 1'b0;
      case (st)
        PK_IDLE: if (pick_vld) begin
          st      <= PK_SEND;
          grant   <= 1'b1;
          grant_q <= pick_idx;
          left    <= (pick_len == '0) ? LEN_W'(1) : pick_len;
        end
        default: begin
          left <= left - LEN_W'(1);
          if (left == LEN_W'(1)) st <= PK_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/egress_cbs_sel.sv
module egress_cbs_sel #(
  parameter int NUM_Q  = 4,
  parameter int PCT_W  = 7,
  parameter int LEN_W  = 12,
  parameter int CRED_W = 24,
  parameter int QI_W   = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_Q-1:0]       shape_en,
  input  logic [NUM_Q*PCT_W-1:0] pct,
  input  logic [NUM_Q-1:0]       q_valid,
  input  logic [NUM_Q*LEN_W-1:0] q_len,
  output logic                   grant,
  output logic [QI_W-1:0]        grant_q,
  output logic                   busy
);
  import cbs_pkg::*;

  logic [NUM_Q-1:0]        shape_eff;
  logic [NUM_Q-1:0]        sending;
  logic [NUM_Q-1:0]        elig_shaped, elig_strict;
  logic [NUM_Q*CRED_W-1:0] cred_flat;
  logic                    pick_vld;
  logic [QI_W-1:0]         pick_idx;
  logic [LEN_W-1:0]        pick_len;

  assign shape_eff[NUM_Q-1] = shape_en[NUM_Q-1];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic signed [CRED_W-1:0] cr;
    if (g < NUM_Q-1) begin : g_run
      assign shape_eff[g] = shape_en[g] & shape_eff[g+1];
    end
    assign sending[g] = busy && (grant_q == QI_W'(g));
    cbs_credit #(.PCT_W(PCT_W), .FRAC_W(CBS_FRAC_W), .CRED_W(CRED_W)) u_cred (
      .clk     (clk),
      .rst     (rst),
      .shaped  (shape_eff[g]),
      .pct     (pct[g*PCT_W +: PCT_W]),
      .waiting (q_valid[g] && !sending[g]),
      .sending (sending[g]),
      .credit  (cr)
    );
    assign cred_flat[g*CRED_W +: CRED_W] = cr;
    assign elig_shaped[g] = shape_eff[g] && q_valid[g] && !cr[CRED_W-1];
    assign elig_strict[g] = !shape_eff[g] && q_valid[g];
  end

  cbs_pick #(.NUM_Q(NUM_Q), .QI_W(QI_W)) u_pick (
    .elig_shaped (elig_shaped),
    .elig_strict (elig_strict),
    .pick_vld    (pick_vld),
    .pick_idx    (pick_idx)
  );

  assign pick_len = q_len[pick_idx*LEN_W +: LEN_W];

  cbs_pkt_timer #(.LEN_W(LEN_W), .QI_W(QI_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx),
    .pick_len (pick_len),
    .grant    (grant),
    .grant_q  (grant_q),
    .busy     (busy)
  );
endmodule

// File: rtl/cbs_sel_chk.sv
module cbs_sel_chk #(
  parameter int NUM_Q  = 4,
  parameter int CRED_W = 24,
  parameter int QI_W   = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_Q-1:0]        q_valid,
  input logic                    grant,
  input logic [QI_W-1:0]         grant_q,
  input logic                    busy,
  input logic [NUM_Q-1:0]        shape_eff,
  input logic [NUM_Q*CRED_W-1:0] cred_flat
);
  logic [NUM_Q-1:0] valid_d, blocked_d;

  always_ff @(posedge clk) begin
    valid_d <= q_valid;
    for (int i = 0; i < NUM_Q; i++)
      blocked_d[i] <= shape_eff[i] && cred_flat[i*CRED_W + CRED_W-1];
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && !grant)); // R1
  AST_GRANT_FROM_VALID: assert property (@(posedge clk) disable iff (rst)
    grant |-> valid_d[grant_q]); // R2
  AST_NO_NEG_GRANT: assert property (@(posedge clk) disable iff (rst)
    grant |-> !blocked_d[grant_q]); // R7
  AST_BUSY_STARTS_WITH_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> grant); // R9
  AST_NO_GRANT_MID_PKT: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !grant); // R9
  AST_GAP_AFTER_PKT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !grant); // R9
  AST_QSTABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && !grant) |-> $stable(grant_q)); // R10

  for (genvar g = 0; g < NUM_Q; g++) begin : g_c
    AST_UNSHAPED_ZERO: assert property (@(posedge clk) disable iff (rst)
      !shape_eff[g] |=> (cred_flat[g*CRED_W +: CRED_W] == '0)); // R3
  end
endmodule

bind egress_cbs_sel cbs_sel_chk #(.NUM_Q(NUM_Q), .CRED_W(CRED_W), .QI_W(QI_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .q_valid   (q_valid),
  .grant     (grant),
  .grant_q   (grant_q),
  .busy      (busy),
  .shape_eff (shape_eff),
  .cred_flat (cred_flat)
);

// File: tb/test_egress_cbs_sel.sv
module test_egress_cbs_sel;
  localparam int NQ = 4, PW = 7, LW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    shape_en = '0;
  logic [4*PW-1:0] pct = '0;
  logic [3:0]    q_valid = '0;
  logic [4*LW-1:0] q_len = '0;
  logic          grant, busy;
  logic [1:0]    grant_q;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  egress_cbs_sel i_egress_cbs_sel (
    .clk(clk), .rst(rst), .shape_en(shape_en), .pct(pct), .q_valid(q_valid),
    .q_len(q_len), .grant(grant), .grant_q(grant_q), .busy(busy)
  );

  // fields: [9:6] shape mask, [5:2] valid, [1:0] expected queue; all pct 100
  localparam logic [9:0] VEC [6] = '{
    {4'b0000, 4'b1111, 2'd3},  // R2
    {4'b0000, 4'b0110, 2'd2},  // R2
    {4'b0000, 4'b0001, 2'd0},  // R2
    {4'b1000, 4'b0111, 2'd2},  // R4
    {4'b1100, 4'b1001, 2'd3},  // R4
    {4'b1110, 4'b0011, 2'd1}   // R4
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_all(input int p, input int l);
    for (int i = 0; i < NQ; i++) begin
      pct[i*PW +: PW] = PW'(p);
      q_len[i*LW +: LW] = LW'(l);
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1; q_valid = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_grant(output int q);
    q = -1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (grant) begin q = int'(grant_q); break; end
    end
  endtask

  task automatic wait_idle;
    for (int k = 0; k < 400; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic run_seq(input string req, input int n, input int exp[8]);
    int q;
    for (int i = 0; i < n; i++) begin
      wait_grant(q);
      chk(q == exp[i], req, q, exp[i]);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int q, cnt;
    set_all(100, 4);
    repeat (2) @(negedge clk);
    chk(!grant && !busy && grant_q == 0, "R1", {grant, busy}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!grant && !busy, "R1", {grant, busy}, 0);
    repeat (3) @(negedge clk);
    chk(!grant && !busy, "R2 no valid no grant", {grant, busy}, 0);

    // table walk: priority ordering with never-negative credit
    foreach (VEC[v]) begin
      @(negedge clk);
      shape_en = VEC[v][9:6];
      q_valid  = VEC[v][5:2];
      wait_grant(q);
      q_valid = '0;
      chk(q == int'(VEC[v][1:0]), v < 3 ? "R2" : "R4", q, int'(VEC[v][1:0]));
      wait_idle();
    end

    // R9 busy length, including zero length
    do_reset(); shape_en = '0; set_all(100, 5);
    q_valid = 4'b0001;
    wait_grant(q); q_valid = '0; cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == 5, "R9 busy length", cnt, 5);
    q_len[0 +: LW] = '0; q_valid = 4'b0001;
    wait_grant(q); q_valid = '0; cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == 1, "R9 zero length", cnt, 1);

    // R10 no preemption, R9 gap
    do_reset(); set_all(100, 6);
    q_valid = 4'b0001;
    wait_grant(q);
    @(negedge clk); q_valid = 4'b1001; cnt = 0;
    while (busy) begin
      if (grant || grant_q != 2'd0) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R10 no preemption", cnt, 0);
    chk(!grant, "R9 idle gap", grant, 0);
    wait_grant(q); q_valid = '0;
    chk(q == 3, "R2 next packet", q, 3);
    wait_idle();

    // R5 R6 R7: queue 3 shaped at 25 percent vs strict queue 0
    do_reset(); shape_en = 4'b1000; set_all(100, 4); pct[3*PW +: PW] = 7'd25;
    @(negedge clk); q_valid = 4'b1001;
    run_seq("R5 R6 R7 shaped share", 8, '{3, 0, 0, 0, 3, 0, 0, 3});
    q_valid = '0; wait_idle();

    // R8 positive credit cleared while empty
    do_reset(); shape_en = 4'b1000; set_all(100, 4); pct[3*PW +: PW] = 7'd25;
    q_len[0 +: LW] = LW'(40);
    q_valid = 4'b0001;
    wait_grant(q);
    q_valid = 4'b1001;
    repeat (10) @(negedge clk);
    q_valid = 4'b0000;
    wait_idle();
    repeat (2) @(negedge clk);
    q_len[0 +: LW] = LW'(4); q_valid = 4'b1001;
    run_seq("R8 cleared credit", 5, '{3, 0, 0, 0, 3, 0, 0, 0});
    q_valid = '0; wait_idle();

    // R8 negative credit recovers to zero and no further
    do_reset(); shape_en = 4'b1000; set_all(100, 4); pct[3*PW +: PW] = 7'd25;
    q_valid = 4'b1000;
    wait_grant(q); q_valid = '0;
    wait_idle();
    repeat (25) @(negedge clk);
    q_valid = 4'b1001;
    run_seq("R8 recover capped", 4, '{3, 0, 0, 0, 0, 0, 0, 0});
    q_valid = '0; wait_idle();

    // R3 mask bit without the bits above is ignored (queue 2, pct 0)
    do_reset(); shape_en = 4'b0100; set_all(100, 4); pct[2*PW +: PW] = 7'd0;
    q_valid = 4'b0100;
    wait_grant(q); q_valid = '0;
    chk(q == 2, "R3", q, 2);
    wait_idle();
    q_valid = 4'b0101;
    wait_grant(q); q_valid = '0;
    chk(q == 2, "R3 non-run bit ignored", q, 2);
    wait_idle();

    // R7 same queue shaped inside a valid run is blocked after sending
    do_reset(); shape_en = 4'b1100;
    q_valid = 4'b0100;
    wait_grant(q); q_valid = '0;
    chk(q == 2, "R4 shaped zero credit", q, 2);
    wait_idle();
    q_valid = 4'b0101;
    wait_grant(q); q_valid = '0;
    chk(q == 0, "R7 negative credit blocked", q, 0);
    wait_idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule